// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time for a chip. A 128 Hz tick enable advances a 7-bit sub-second counter. Each wrap of that counter steps a BCD calendar chain: seconds, minutes, hours, weekday, day of month, month and a four-digit year. Month length and the leap-year rule are applied when the day steps. Every counter field is read and written through a small register bus with 16-bit data. Byte-wide fields use the low byte and read zero in the high byte.

Two control registers hold the run state. Software stops the clock and holds the prescaler in reset while it writes a new time. It then releases the prescaler and sets the start and valid bits. A sticky carry flag is set on every seconds step and is cleared only when software writes it with 0. Software clears the flag, reads all the fields, and checks the flag again. If the flag is set, a rollover may have split the read, so software reads the fields again. The flag can also drive a level interrupt.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the registers read as follows: sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0, day 0x01, month 0x01, year 0x2000, both control registers 0. The interrupt output is low.
- R2: The register indices are: sub-second 0, seconds 1, minutes 2, hours 3, weekday 4, day 5, month 6, year 7 (century in bits 15:8, year of century in bits 7:0, both BCD), control-A 14, control-B 15. Any other index reads 0, and a write to it changes nothing.
- R3: The sub-second counter advances once per cycle with tick_128 high, while control-B bit 0 (start) is 1 and control-B bit 1 (prescaler reset) is 0. On the step from 127 to 0, the seconds advance by one.
- R4: With start at 0, ticks change no counter. With prescaler reset at 1, the sub-second counter is held at 0 and the seconds do not advance.
- R5: Seconds and minutes roll from 0x59 to 0x00, and hours roll from 0x23 to 0x00. Each rollover carries into the next field.
- R6: Weekday steps with each day carry and wraps from 6 to 0.
- R7: The day rolls to 0x01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days and February has 28 days. In a leap year February has 29 days. A year is a leap year when it divides by 4, except a century year, which is a leap year only when it divides by 400. All other months have 31 days.
- R8: Month rolls from 0x12 to 0x01 and carries into the year. The year of century rolls from 0x99 to 0x00 and advances the century.
- R9: Control-A bit 7 is the carry flag. It is set on every seconds step. Writing control-A with bit 7 = 0 clears it, and writing it with bit 7 = 1 leaves it unchanged. If a seconds step and a clearing write fall in the same cycle, the flag ends set.
- R10: irq_carry is high exactly while the carry flag and control-A bit 4 (carry interrupt enable) are both 1.
- R11: A write to a counter field is visible on the next cycle. The write neither sets the carry flag nor changes any other field.
- R12: Control-B bit 3 (valid), bit 1 and bit 0 read back as written, and its other bits read 0. Control-A reads back only bits 7 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_128 | input | 1 | One-cycle pulse at 128 Hz |
| bus_addr | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe for the indexed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the indexed register, combinational |
| irq_carry | output | 1 | Level carry interrupt |

## Verification
The range assertions assume that software writes only legal BCD values into the counters. Seconds and minutes are at most 0x59, hours at most 0x23, weekday at most 6, month between 0x01 and 0x12, and the day is within its month. The stimulus writes only such values. Writes that load a time are never issued in the same cycle as a tick, so the written field and the counting logic never compete for one field. The single exception is the clearing write to the carry flag, which the bench deliberately places on a tick cycle to exercise the set-wins rule.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // register indices (software decodes these)
  localparam logic [3:0] IDX_SUB   = 4'd0;
  localparam logic [3:0] IDX_YEAR  = 4'd7;
  localparam logic [3:0] IDX_CTLA  = 4'd14;
  localparam logic [3:0] IDX_CTLB  = 4'd15;

  // control bit positions
  localparam int CA_FLAG  = 7;
  localparam int CA_IE    = 4;
  localparam int CB_VALID = 3;
  localparam int CB_PRST  = 1;
  localparam int CB_START = 0;

  typedef struct packed {
    logic [15:0] year;
    logic [7:0]  mon;
    logic [7:0]  day;
    logic [7:0]  wday;
    logic [7:0]  hour;
    logic [7:0]  min;
    logic [7:0]  sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [15:0] y);
    logic [6:0] yy;
    logic [6:0] cc;
    yy = bcd2bin(y[7:0]);
    cc = bcd2bin(y[15:8]);
    if (yy != 7'd0) return (yy[1:0] == 2'b00);
    return (cc[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [PRE_W-1:0] wr_val,
  output logic [PRE_W-1:0] count,
  output logic             sec_step
);
  localparam logic [PRE_W-1:0] LAST = '1;

  logic advance;
  assign advance  = tick && run && !hold;
  assign sec_step = advance && !wr_en && (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (hold)    count <= '0;
    else if (wr_en)   count <= wr_val;
    else if (advance) count <= count + 1'b1;
  end

  AST_PRESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0)); // R4
  AST_SUB_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> (count == '0)); // R3
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter logic [15:0] RESET_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        wr_en,
  input  logic [2:0]  wr_field,
  input  logic [15:0] wr_data,
  output cal_t        cal
);
  cal_t nxt;
  logic sec_end, min_end, hour_end, day_end, mon_end, yy_end;
  logic [7:0] last_day;

  assign last_day = month_len(cal.mon, leap_year(cal.year));
  assign sec_end  = (cal.sec  == 8'h59);
  assign min_end  = (cal.min  == 8'h59);
  assign hour_end = (cal.hour == 8'h23);
  assign day_end  = (cal.day  == last_day);
  assign mon_end  = (cal.mon  == 8'h12);
  assign yy_end   = (cal.year[7:0] == 8'h99);

  always_comb begin
    nxt = cal;
    if (step) begin
      nxt.sec = sec_end ? 8'h00 : bcd_inc(cal.sec);
      if (sec_end) begin
        nxt.min = min_end ? 8'h00 : bcd_inc(cal.min);
        if (min_end) begin
          nxt.hour = hour_end ? 8'h00 : bcd_inc(cal.hour);
          if (hour_end) begin
            nxt.wday = (cal.wday == 8'h06) ? 8'h00 : bcd_inc(cal.wday);
            nxt.day  = day_end ? 8'h01 : bcd_inc(cal.day);
            if (day_end) begin
              nxt.mon = mon_end ? 8'h01 : bcd_inc(cal.mon);
              if (mon_end) begin
                nxt.year[7:0] = yy_end ? 8'h00 : bcd_inc(cal.year[7:0]);
                if (yy_end)
                  nxt.year[15:8] = (cal.year[15:8] == 8'h99) ? 8'h00 : bcd_inc(cal.year[15:8]);
              end
            end
          end
        end
      end
    end
    if (wr_en) begin
      case (wr_field)
        3'd1: nxt.sec  = wr_data[7:0];
        3'd2: nxt.min  = wr_data[7:0];
        3'd3: nxt.hour = wr_data[7:0];
        3'd4: nxt.wday = wr_data[7:0];
        3'd5: nxt.day  = wr_data[7:0];
        3'd6: nxt.mon  = wr_data[7:0];
        3'd7: nxt.year = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal      <= '0;
      cal.day  <= 8'h01;
      cal.mon  <= 8'h01;
      cal.year <= RESET_YEAR;
    end else begin
      cal <= nxt;
    end
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal.sec <= 8'h59) && (cal.sec[3:0] <= 4'd9)); // R5
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cal.hour <= 8'h23); // R5
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cal.wday <= 8'h06); // R6
  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal.mon >= 8'h01) && (cal.mon <= 8'h12)); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> $stable(cal)); // R4
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  input  logic       sec_step,
  output logic       carry_flag,
  output logic       carry_ie,
  output logic       valid,
  output logic       prs_rst,
  output logic       start
);
  logic unused_bits;
  assign unused_bits = ^{wdata[6:5], wdata[2]};

  logic clr_req;
  assign clr_req = wr_a && !wdata[CA_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_flag <= 1'b0;
      carry_ie   <= 1'b0;
      valid      <= 1'b0;
      prs_rst    <= 1'b0;
      start      <= 1'b0;
    end else begin
      if (sec_step)     carry_flag <= 1'b1;
      else if (clr_req) carry_flag <= 1'b0;
      if (wr_a) carry_ie <= wdata[CA_IE];
      if (wr_b) begin
        valid   <= wdata[CB_VALID];
        prs_rst <= wdata[CB_PRST];
        start   <= wdata[CB_START];
      end
    end
  end

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> carry_flag); // R9
  AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_flag && !clr_req) |=> carry_flag); // R9
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int          PRE_W      = 7,
  parameter logic [15:0] RESET_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_128,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_carry
);
  localparam int PAD_W = 16 - PRE_W;

  logic [PRE_W-1:0] sub_cnt;
  logic             sec_step;
  logic             carry_flag, carry_ie, valid, prs_rst, start;
  cal_t             cal;

  logic wr_sub, wr_cal, wr_a, wr_b;
  assign wr_sub = bus_wr && (bus_addr == IDX_SUB);
  assign wr_cal = bus_wr && (bus_addr != IDX_SUB) && (bus_addr <= IDX_YEAR);
  assign wr_a   = bus_wr && (bus_addr == IDX_CTLA);
  assign wr_b   = bus_wr && (bus_addr == IDX_CTLB);

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_128), .run(start), .hold(prs_rst),
    .wr_en(wr_sub), .wr_val(bus_wdata[PRE_W-1:0]), .count(sub_cnt), .sec_step(sec_step)
  );

  rtc_calendar #(.RESET_YEAR(RESET_YEAR)) u_cal (
    .clk(clk), .rst_n(rst_n), .step(sec_step), .wr_en(wr_cal),
    .wr_field(bus_addr[2:0]), .wr_data(bus_wdata), .cal(cal)
  );

  rtc_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wdata(bus_wdata[7:0]),
    .sec_step(sec_step), .carry_flag(carry_flag), .carry_ie(carry_ie),
    .valid(valid), .prs_rst(prs_rst), .start(start)
  );

  always_comb begin
    case (bus_addr)
      4'd0:    bus_rdata = {{PAD_W{1'b0}}, sub_cnt};
      4'd1:    bus_rdata = {8'h00, cal.sec};
      4'd2:    bus_rdata = {8'h00, cal.min};
      4'd3:    bus_rdata = {8'h00, cal.hour};
      4'd4:    bus_rdata = {8'h00, cal.wday};
      4'd5:    bus_rdata = {8'h00, cal.day};
      4'd6:    bus_rdata = {8'h00, cal.mon};
      4'd7:    bus_rdata = cal.year;
      4'd14:   bus_rdata = {8'h00, carry_flag, 2'b00, carry_ie, 4'b0000};
      4'd15:   bus_rdata = {12'h000, valid, 1'b0, prs_rst, start};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq_carry = carry_flag && carry_ie;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && carry_ie && !wr_a) |=> irq_carry); // R10
endmodule

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_128 = 1'b0;
  logic [3:0]  drv_addr = 4'd0;
  logic [3:0]  mon_addr = 4'd0;
  logic        mon_busy = 1'b0;
  logic [3:0]  bus_addr;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq_carry;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign bus_addr = mon_busy ? mon_addr : drv_addr;

  rtc_calendar_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_128(tick_128), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_carry(irq_carry)
  );

  typedef struct {
    bit          is_irq;
    logic [3:0]  a;
    logic [15:0] v;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic exp_reg(input logic [3:0] a, input logic [15:0] v, input string tag);
    sb_item_t it;
    it.is_irq = 0; it.a = a; it.v = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_irq(input logic v, input string tag);
    sb_item_t it;
    it.is_irq = 1; it.a = 4'd0; it.v = {15'd0, v}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0 || mon_busy) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    drain();
    drv_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    drain();
    tick_128 = 1'b1;
    repeat (n) @(negedge clk);
    tick_128 = 1'b0;
  endtask

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      sb_item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      mon_busy = 1'b1;
      mon_addr = it.a;
      #1;
      act = it.is_irq ? {15'd0, irq_carry} : bus_rdata;
      n_cmp++;
      if (act !== it.v) begin
        n_bad++;
        $display("FAIL %s: %s actual %h expected %h", it.tag,
                 it.is_irq ? "irq" : $sformatf("reg %0d", it.a), act, it.v);
      end
      mon_busy = 1'b0;
    end
  end

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                          input logic [15:0] y);
    wr(4'd0, 16'h007F);
    wr(4'd1, {8'h0, s}); wr(4'd2, {8'h0, m}); wr(4'd3, {8'h0, h});
    wr(4'd4, {8'h0, w}); wr(4'd5, {8'h0, d}); wr(4'd6, {8'h0, mo});
    wr(4'd7, y);
    wr(4'd14, 16'h0010);
  endtask

  task automatic exp_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                          input logic [15:0] y, input string tag);
    exp_reg(4'd1, {8'h0, s}, tag); exp_reg(4'd2, {8'h0, m}, tag);
    exp_reg(4'd3, {8'h0, h}, tag); exp_reg(4'd4, {8'h0, w}, tag);
    exp_reg(4'd5, {8'h0, d}, tag); exp_reg(4'd6, {8'h0, mo}, tag);
    exp_reg(4'd7, y, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R2 unmapped index
    exp_reg(4'd0, 16'h0, "R1");
    exp_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 16'h2000, "R1");
    exp_reg(4'd14, 16'h0, "R1"); exp_reg(4'd15, 16'h0, "R1");
    exp_irq(1'b0, "R1");
    exp_reg(4'd8, 16'h0, "R2");
    // R4 stopped clock ignores ticks
    ticks(5);
    exp_reg(4'd0, 16'h0, "R4"); exp_reg(4'd1, 16'h0, "R4");
    // R12 control readback
    wr(4'd15, 16'h00FF);
    exp_reg(4'd15, 16'h000B, "R12");
    wr(4'd15, 16'h0009);
    exp_reg(4'd15, 16'h0009, "R12");
    // R3 sub-second counting and carry into seconds
    ticks(5);
    exp_reg(4'd0, 16'h0005, "R3");
    ticks(123);
    exp_reg(4'd0, 16'h0000, "R3"); exp_reg(4'd1, 16'h0001, "R3");
    exp_reg(4'd14, 16'h0080, "R9"); exp_irq(1'b0, "R10");
    // R9 writing 1 keeps flag; R10 irq level
    wr(4'd14, 16'h0090);
    exp_reg(4'd14, 16'h0090, "R9"); exp_irq(1'b1, "R10");
    wr(4'd14, 16'h0010);
    exp_reg(4'd14, 16'h0010, "R9"); exp_irq(1'b0, "R10");
    // R4 prescaler reset holds sub-second at zero
    wr(4'd0, 16'h0040);
    wr(4'd15, 16'h000B);
    ticks(140);
    exp_reg(4'd0, 16'h0, "R4"); exp_reg(4'd1, 16'h0001, "R4");
    wr(4'd15, 16'h0009);
    // R2 write to unmapped index changes nothing
    wr(4'd8, 16'h0055);
    exp_reg(4'd8, 16'h0, "R2"); exp_reg(4'd1, 16'h0001, "R2");
    // R11 write has no carry side effect
    wr(4'd0, 16'h007F);
    wr(4'd1, 16'h0059);
    exp_reg(4'd1, 16'h0059, "R11"); exp_reg(4'd2, 16'h0000, "R11");
    exp_reg(4'd14, 16'h0010, "R11"); exp_reg(4'd0, 16'h007F, "R11");
    ticks(1);
    exp_reg(4'd1, 16'h0000, "R5"); exp_reg(4'd2, 16'h0001, "R5");
    exp_reg(4'd14, 16'h0090, "R9"); exp_irq(1'b1, "R10");
    // R5 hour carry without day change
    set_time(8'h59, 8'h59, 8'h10, 8'h03, 8'h12, 8'h05, 16'h2023);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h11, 8'h03, 8'h12, 8'h05, 16'h2023, "R5");
    // R5 R6 midnight, weekday wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h15, 8'h01, 16'h2000);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h16, 8'h01, 16'h2000, "R6");
    // R7 month lengths and leap rules
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 16'h2023);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 16'h2023, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 16'h2023);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 16'h2023, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 16'h2024);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 16'h2024, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 16'h2000);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 16'h2000, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 16'h2000);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 16'h2000, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h00, 8'h28, 8'h02, 16'h2100);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 16'h2100, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 16'h2023);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h05, 16'h2023, "R7");
    // R8 year and century carry
    set_time(8'h59, 8'h59, 8'h23, 8'h00, 8'h31, 8'h12, 16'h2023);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 16'h2024, "R8");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 16'h2099);
    ticks(1);
    exp_time(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 16'h2100, "R8");
    exp_reg(4'd14, 16'h0090, "R9");
    // R9 step and clearing write in the same cycle: set wins
    wr(4'd14, 16'h0010);
    wr(4'd0, 16'h007F);
    exp_reg(4'd14, 16'h0010, "R9");
    drain();
    drv_addr = 4'd14; bus_wdata = 16'h0010; bus_wr = 1'b1; tick_128 = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_128 = 1'b0;
    exp_reg(4'd14, 16'h0090, "R9"); exp_reg(4'd1, 16'h0001, "R9");
    // R4 stop freezes everything
    wr(4'd15, 16'h0008);
    ticks(200);
    exp_reg(4'd0, 16'h0, "R4"); exp_reg(4'd1, 16'h0001, "R4");
    exp_reg(4'd15, 16'h0008, "R12");
    drain();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule